// File: doc/BRIEF.md
# Host-to-DMA Data Request FIFO

This block carries 16-bit words from a host processor into the memory of a second processor. The host programs a word count into a length register, sets an enable bit in a control register, and then writes words one at a time into a FIFO data register. The FIFO holds up to eight words. Each time a push leaves the FIFO holding a whole group of four words, the block checks whether DMA channel 0 is armed. If it is, the block empties the FIFO through a 16-bit memory write port, one word per accepted cycle.

The channel side holds a destination address, a 24-bit transfer count, a channel control word and a DMA operation word. Each word the block writes moves the destination forward by two bytes and takes one from both the channel count and the host length. Each counter has its own end condition. When the host length runs out, the host enable bit is cleared. When the channel count runs out, the transfer-end flag in the channel control word is set and draining stops early. The memory port uses a write strobe and a ready input. A write is accepted only in a cycle where both are high.

Top module: `dreq_bridge`

## Requirements
- R1: A host write of the length register (host select 0) stores the data with bits [1:0] forced to zero.
- R2: A host write of the FIFO data register (host select 2) does not change the FIFO. This holds in three cases: the enable bit (control bit 2) is clear, the FIFO already holds eight words, or a drain is in progress.
- R3: A drain starts only after a push that brings the FIFO level to 4 or 8, and only if channel control bits [1:0] are 2'b01 and DMA operation bit 0 is 1. Without both conditions, the words stay in the FIFO.
- R4: The FULL bit (control bit 7) is set when a push brings the level to eight. At the end of every drain it is cleared, and the level returns to zero, so undrained words are discarded.
- R5: The words are drained oldest first. Each word is written to the current destination address. After each accepted write, the destination increases by 2 and the channel count and host length each decrease by 1. When ready is low, the write holds unchanged.
- R6: No memory write is issued while the channel count is zero, so a drain stops as soon as the count reaches zero.
- R7: At the end of a drain that leaves the host length at zero, the enable bit (control bit 2) is cleared.
- R8: At the end of a drain that leaves the channel count at zero, channel control bit 1 (transfer end) is set.
- R9: A host write of the control register (host select 1) updates only bit 2 (enable), bit 1 (DMA) and bit 0 (RV) from the data, and keeps the current FULL bit. The control readback is {8'h00, FULL, 4'b0000, enable, DMA, RV}.
- R10: A channel count write (channel select 1) keeps only data bits [23:0]. The destination (select 0) takes all 32 bits. The channel control (select 2) and DMA operation (select 3) registers take bits [15:0].
- R11: Channel register writes made while a drain is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en_i | input | 1 | Host register write strobe |
| host_wr_sel_i | input | 2 | Host register select: 0 length, 1 control, 2 FIFO data |
| host_wr_data_i | input | 16 | Host write data |
| host_len_o | output | 16 | Host length register |
| host_ctrl_o | output | 16 | Control readback {8'h00, FULL, 4'b0, enable, DMA, RV} |
| fifo_level_o | output | 4 | Words held in the FIFO |
| ch_wr_en_i | input | 1 | Channel register write strobe |
| ch_wr_sel_i | input | 2 | Channel select: 0 destination, 1 count, 2 control, 3 DMA operation |
| ch_wr_data_i | input | 32 | Channel write data |
| ch_dst_o | output | 32 | Current destination address |
| ch_count_o | output | 24 | Remaining channel transfer count |
| ch_ctl_o | output | 16 | Channel control word (bit 1 is transfer end) |
| ch_op_o | output | 16 | DMA operation word (bit 0 is global enable) |
| busy_o | output | 1 | A drain is in progress |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory write address |
| mem_data_o | output | 16 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |

## Verification
The assertions assume two things about the inputs. First, the host length register is not zero when a drain begins, because the length decrements without saturating. Second, the memory side eventually raises ready, so a stalled write cannot hold the drain forever. The stimulus always loads a length that covers every word it pushes, and it drives ready either high or alternating each cycle. Pushes and channel writes made during a drain are deliberately placed in the busy window to exercise the ignore rules. The scoreboard matches every word written to memory against its expected address and data.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 24;

  localparam int unsigned CTRL_RV   = 0;
  localparam int unsigned CTRL_DMA  = 1;
  localparam int unsigned CTRL_EN   = 2;
  localparam int unsigned CTRL_FULL = 7;
  localparam int unsigned CHCTL_END = 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {HR_LEN = 2'd0, HR_CTRL = 2'd1, HR_FIFO = 2'd2, HR_NONE = 2'd3} host_reg_e;
  typedef enum logic [1:0] {CR_DST = 2'd0, CR_CNT = 2'd1, CR_CTL = 2'd2, CR_OP = 2'd3} chan_reg_e;
  typedef enum logic [1:0] {DS_IDLE = 2'd0, DS_RUN = 2'd1, DS_DONE = 2'd2} drain_state_e;

  function automatic word_t len_align(word_t d);
    return d & ~word_t'(3);
  endfunction

  function automatic addr_t dst_advance(addr_t a);
    return a + addr_t'(2);
  endfunction

  function automatic logic mode_armed(word_t ctl, word_t op);
    return (ctl[1:0] == 2'b01) && op[0];
  endfunction

  function automatic logic group_edge(int unsigned lvl, int unsigned grp);
    return (lvl != 0) && ((lvl % grp) == 0);
  endfunction
endpackage

// File: rtl/dreq_fifo.sv
module dreq_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             flush_i,
  input  logic [LVL_W-1:0] rd_idx_i,
  output logic [LVL_W-1:0] level_o,
  output logic [DW-1:0]    rd_data_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    slot_q [DEPTH];
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (push_i && (level_q == LVL_W'(s))) slot_q[s] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       level_q <= '0;
    else if (flush_i) level_q <= '0;
    else if (push_i)  level_q <= level_q + LVL_W'(1);
  end

  assign level_o   = level_q;
  assign rd_data_o = slot_q[rd_idx_i[IDX_W-1:0]];

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));

  assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (level_q < LVL_W'(DEPTH)));
endmodule

// File: rtl/dreq_chan_regs.sv
module dreq_chan_regs
  import dreq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        step_i,
  input  logic        end_set_i,
  output addr_t       dst_o,
  output cnt_t        count_o,
  output word_t       ctl_o,
  output word_t       op_o
);
  addr_t dst_q;
  cnt_t  count_q;
  word_t ctl_q, op_q;

  logic wr_dst, wr_cnt, wr_ctl, wr_op;
  assign wr_dst = wr_en_i && (wr_sel_i == CR_DST);
  assign wr_cnt = wr_en_i && (wr_sel_i == CR_CNT);
  assign wr_ctl = wr_en_i && (wr_sel_i == CR_CTL);
  assign wr_op  = wr_en_i && (wr_sel_i == CR_OP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q   <= '0;
      count_q <= '0;
    end else begin
      if (wr_dst)      dst_q <= addr_t'(wr_data_i);
      else if (step_i) dst_q <= dst_advance(dst_q);
      if (wr_cnt)      count_q <= wr_data_i[CNT_W-1:0];
      else if (step_i) count_q <= count_q - cnt_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      op_q  <= '0;
    end else begin
      if (wr_ctl)         ctl_q <= wr_data_i[WORD_W-1:0];
      else if (end_set_i) ctl_q[CHCTL_END] <= 1'b1;
      if (wr_op)          op_q <= wr_data_i[WORD_W-1:0];
    end
  end

  assign dst_o   = dst_q;
  assign count_o = count_q;
  assign ctl_o   = ctl_q;
  assign op_o    = op_q;

  assert_cnt_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_q == $past(wr_data_i[CNT_W-1:0])));
endmodule

// File: rtl/dreq_drain_ctl.sv
module dreq_drain_ctl
  import dreq_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             count_zero_i,
  input  logic             count_one_i,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             mem_wr_o,
  output logic [LVL_W-1:0] rd_idx_o,
  output logic             step_o,
  output logic             done_o
);
  drain_state_e     state_q, state_d;
  logic [LVL_W-1:0] idx_q;
  logic             last_word;

  always_comb begin
    mem_wr_o  = (state_q == DS_RUN) && (idx_q < level_i) && !count_zero_i;
    step_o    = mem_wr_o && mem_ready_i;
    last_word = step_o && (((idx_q + LVL_W'(1)) == level_i) || count_one_i);
    done_o    = (state_q == DS_DONE);
    busy_o    = (state_q != DS_IDLE);
    state_d   = state_q;
    case (state_q)
      DS_IDLE: if (start_i) state_d = DS_RUN;
      DS_RUN:  if (!mem_wr_o || last_word) state_d = DS_DONE;
      DS_DONE: state_d = DS_IDLE;
      default: state_d = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == DS_IDLE && start_i) idx_q <= '0;
      else if (step_o)                   idx_q <= idx_q + LVL_W'(1);
    end
  end

  assign rd_idx_o = idx_q;

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(rd_idx_o)));

  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (rd_idx_o < level_i));
endmodule

// File: rtl/dreq_bridge.sv
module dreq_bridge
  import dreq_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned GROUP = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en_i,
  input  logic [1:0]       host_wr_sel_i,
  input  logic [15:0]      host_wr_data_i,
  output logic [15:0]      host_len_o,
  output logic [15:0]      host_ctrl_o,
  output logic [LVL_W-1:0] fifo_level_o,
  input  logic             ch_wr_en_i,
  input  logic [1:0]       ch_wr_sel_i,
  input  logic [31:0]      ch_wr_data_i,
  output logic [31:0]      ch_dst_o,
  output logic [23:0]      ch_count_o,
  output logic [15:0]      ch_ctl_o,
  output logic [15:0]      ch_op_o,
  output logic             busy_o,
  output logic             mem_wr_o,
  output logic [31:0]      mem_addr_o,
  output logic [15:0]      mem_data_o,
  input  logic             mem_ready_i
);
  word_t len_q;
  logic  en_q, dma_q, rv_q, full_q;

  logic [LVL_W-1:0] level, rd_idx;
  word_t rd_data;
  addr_t dst;
  cnt_t  count;
  word_t ctl, op;
  logic  busy, step, done, start;

  logic host_len_wr, host_ctrl_wr, host_fifo_wr, push_ok, end_set, ch_wr_ok;

  assign host_len_wr  = host_wr_en_i && (host_wr_sel_i == HR_LEN);
  assign host_ctrl_wr = host_wr_en_i && (host_wr_sel_i == HR_CTRL);
  assign host_fifo_wr = host_wr_en_i && (host_wr_sel_i == HR_FIFO);
  assign push_ok      = host_fifo_wr && en_q && !busy && (level < LVL_W'(DEPTH));
  assign start        = push_ok && mode_armed(ctl, op) &&
                        group_edge(int'(level) + 1, GROUP);
  assign end_set      = done && (count == '0);
  assign ch_wr_ok     = ch_wr_en_i && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)           len_q <= '0;
    else if (host_len_wr) len_q <= len_align(host_wr_data_i);
    else if (step)        len_q <= len_q - word_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      rv_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (host_ctrl_wr) begin
        en_q  <= host_wr_data_i[CTRL_EN];
        dma_q <= host_wr_data_i[CTRL_DMA];
        rv_q  <= host_wr_data_i[CTRL_RV];
      end
      if (done && (len_q == '0)) en_q <= 1'b0;
      if (push_ok && (level == LVL_W'(DEPTH - 1))) full_q <= 1'b1;
      else if (done)                               full_q <= 1'b0;
    end
  end

  dreq_fifo #(.DW(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_ok),
    .push_data_i (host_wr_data_i),
    .flush_i     (done),
    .rd_idx_i    (rd_idx),
    .level_o     (level),
    .rd_data_o   (rd_data)
  );

  dreq_chan_regs u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (ch_wr_ok),
    .wr_sel_i  (ch_wr_sel_i),
    .wr_data_i (ch_wr_data_i),
    .step_i    (step),
    .end_set_i (end_set),
    .dst_o     (dst),
    .count_o   (count),
    .ctl_o     (ctl),
    .op_o      (op)
  );

  dreq_drain_ctl #(.LVL_W(LVL_W)) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .level_i      (level),
    .count_zero_i (count == '0),
    .count_one_i  (count == cnt_t'(1)),
    .mem_ready_i  (mem_ready_i),
    .busy_o       (busy),
    .mem_wr_o     (mem_wr_o),
    .rd_idx_o     (rd_idx),
    .step_o       (step),
    .done_o       (done)
  );

  assign host_len_o   = len_q;
  assign host_ctrl_o  = {8'h00, full_q, 4'b0000, en_q, dma_q, rv_q};
  assign fifo_level_o = level;
  assign ch_dst_o     = dst;
  assign ch_count_o   = count;
  assign ch_ctl_o     = ctl;
  assign ch_op_o      = op;
  assign busy_o       = busy;
  assign mem_addr_o   = dst;
  assign mem_data_o   = rd_data;

  assert_len_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_len_wr |=> (len_q[1:0] == 2'b00));

  assert_ignore_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fifo_wr && !en_q && !busy) |=> (level == $past(level)));

  assert_start_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctl[1:0]) == 2'b01 && $past(op[0])));

  assert_full_on_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && level == LVL_W'(DEPTH - 1)) |=> full_q);

  assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!full_q && level == '0));

  assert_dst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && mem_ready_i) |=> (mem_addr_o == $past(mem_addr_o) + 32'd2));

  assert_count_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (count != '0));

  assert_en_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_q == '0) |=> !en_q);

  assert_end_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && count == '0) |=> ctl[CHCTL_END]);

  assert_ctrl_keep_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctrl_wr && !done && !push_ok) |=> (full_q == $past(full_q)));

  assert_busy_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr_en_i && ch_wr_sel_i == CR_OP && busy) |=> $stable(op));
endmodule

// File: tb/sim_dreq_bridge.sv
`timescale 1ns/1ps
module sim_dreq_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_wr_sel = 2'd3;
  logic [15:0] host_wr_data = '0;
  logic [15:0] host_len, host_ctrl;
  logic [3:0]  fifo_level;
  logic        ch_wr_en = 1'b0;
  logic [1:0]  ch_wr_sel = 2'd0;
  logic [31:0] ch_wr_data = '0;
  logic [31:0] ch_dst;
  logic [23:0] ch_count;
  logic [15:0] ch_ctl, ch_op;
  logic        busy, mem_wr;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic        mem_ready = 1'b1;
  logic        stall_mode = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  int n_mem = 0;
  logic [47:0] exp_q[$];
  logic [31:0] m_dst;

  always #10 clk = ~clk;

  dreq_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en_i(host_wr_en), .host_wr_sel_i(host_wr_sel), .host_wr_data_i(host_wr_data),
    .host_len_o(host_len), .host_ctrl_o(host_ctrl), .fifo_level_o(fifo_level),
    .ch_wr_en_i(ch_wr_en), .ch_wr_sel_i(ch_wr_sel), .ch_wr_data_i(ch_wr_data),
    .ch_dst_o(ch_dst), .ch_count_o(ch_count), .ch_ctl_o(ch_ctl), .ch_op_o(ch_op),
    .busy_o(busy), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ready_i(mem_ready)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each accepted memory write with the queue
  always @(posedge clk) begin
    if (rst_n && mem_wr && mem_ready) begin
      n_mem++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R5 unexpected write actual=%0h expected=none", {mem_addr, mem_data});
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_data} !== e) begin
          n_err++;
          $display("FAIL R5 write actual=%0h expected=%0h", {mem_addr, mem_data}, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (stall_mode) mem_ready = ~mem_ready;
      else            mem_ready = 1'b1;
    end
  end

  task automatic host_wr(logic [1:0] sel, logic [15:0] d);
    host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wr_sel = 2'd3;
  endtask

  task automatic ch_wr(logic [1:0] sel, logic [31:0] d);
    ch_wr_en = 1'b1; ch_wr_sel = sel; ch_wr_data = d;
    @(negedge clk);
    ch_wr_en = 1'b0;
  endtask

  task automatic expect_words(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({m_dst, base + 16'(i)});
      m_dst = m_dst + 32'd2;
    end
  endtask

  task automatic push_words(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) host_wr(2'd2, base + 16'(i));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset ctrl", {16'h0, host_ctrl}, 32'h0);
    chk("reset len", {16'h0, host_len}, 32'h0);
    chk("reset level/busy", {27'h0, fifo_level, busy}, 32'h0);

    // R1 length alignment
    host_wr(2'd0, 16'h0013);
    chk("R1 len low bits", {16'h0, host_len}, 32'h10);

    // R2 push with enable clear
    host_wr(2'd2, 16'h1111);
    chk("R2 push ignored when disabled", {28'h0, fifo_level}, 32'h0);

    // channel setup, R10 count width
    ch_wr(2'd0, 32'h0600_0100);
    ch_wr(2'd1, 32'hAB00_0008);
    chk("R10 count masked", {8'h0, ch_count}, 32'h8);
    ch_wr(2'd2, 32'h0000_0001);
    ch_wr(2'd3, 32'h0000_0001);
    m_dst = 32'h0600_0100;

    // R9 control write preserves FULL, writes only low bits
    host_wr(2'd1, 16'h0087);
    chk("R9 ctrl write", {16'h0, host_ctrl}, 32'h0007);

    // basic group drain
    expect_words(4, 16'hA000);
    push_words(4, 16'hA000);
    wait_idle();
    chk("R5 dst after group", ch_dst, m_dst);
    chk("R5 count after group", {8'h0, ch_count}, 32'h4);
    chk("R5 len after group", {16'h0, host_len}, 32'h0C);
    chk("R4 level zero after drain", {28'h0, fifo_level}, 32'h0);

    // stalled drain with ignored push and channel write (R2, R11, R8)
    stall_mode = 1'b1;
    expect_words(4, 16'hB000);
    push_words(4, 16'hB000);
    chk("R5 busy during drain", {31'h0, busy}, 32'h1);
    ch_wr(2'd0, 32'h0000_0000);
    host_wr(2'd2, 16'hDEAD);
    wait_idle();
    stall_mode = 1'b0;
    chk("R11 dst write ignored while busy", ch_dst, m_dst);
    chk("R2 push ignored while busy", {28'h0, fifo_level}, 32'h0);
    chk("R8 end flag", {16'h0, ch_ctl}, 32'h0003);
    chk("R7 enable kept while len nonzero", {16'h0, host_ctrl}, 32'h0007);

    // R7: length runs out over two groups
    ch_wr(2'd1, 32'h0000_0008);
    ch_wr(2'd2, 32'h0000_0001);
    expect_words(8, 16'hC000);
    push_words(4, 16'hC000);
    wait_idle();
    push_words(4, 16'hC004);
    wait_idle();
    chk("R7 len zero", {16'h0, host_len}, 32'h0);
    chk("R7 enable cleared", {16'h0, host_ctrl}, 32'h0003);
    chk("R8 end flag again", {16'h0, ch_ctl}, 32'h0003);

    // R6: count runs out before the group is drained
    host_wr(2'd0, 16'h0010);
    host_wr(2'd1, 16'h0004);
    ch_wr(2'd1, 32'h0000_0002);
    ch_wr(2'd2, 32'h0000_0001);
    expect_words(2, 16'hD000);
    push_words(4, 16'hD000);
    wait_idle();
    chk("R6 dst stops early", ch_dst, m_dst);
    chk("R6 count zero", {8'h0, ch_count}, 32'h0);
    chk("R6 len", {16'h0, host_len}, 32'h0E);
    chk("R6 rest discarded", {28'h0, fifo_level}, 32'h0);
    chk("R8 end flag early stop", {16'h0, ch_ctl}, 32'h0003);

    // R3: global enable off holds the words; then a full drain of eight
    host_wr(2'd0, 16'h0020);
    ch_wr(2'd1, 32'h0000_0010);
    ch_wr(2'd2, 32'h0000_0001);
    ch_wr(2'd3, 32'h0000_0000);
    push_words(4, 16'hE000);
    repeat (3) @(negedge clk);
    chk("R3 no drain without global enable", {27'h0, fifo_level, busy}, {27'h0, 4'd4, 1'b0});
    ch_wr(2'd3, 32'h0000_0001);
    expect_words(8, 16'hE000);
    push_words(4, 16'hE004);
    chk("R4 full set at capacity", {31'h0, host_ctrl[7]}, 32'h1);
    wait_idle();
    chk("R4 full cleared after drain", {16'h0, host_ctrl}, 32'h0004);
    chk("R5 dst after eight", ch_dst, m_dst);
    chk("R5 count after eight", {8'h0, ch_count}, 32'h8);

    // R3 wrong mode: words accumulate to full, ninth push ignored
    ch_wr(2'd2, 32'h0000_0002);
    push_words(8, 16'hF000);
    repeat (2) @(negedge clk);
    chk("R3 no drain in wrong mode", {31'h0, busy}, 32'h0);
    chk("R4 full in wrong mode", {16'h0, host_ctrl}, 32'h0084);
    host_wr(2'd2, 16'hF0F0);
    chk("R2 push ignored when full", {28'h0, fifo_level}, 32'h8);
    host_wr(2'd1, 16'h0006);
    chk("R9 full kept on ctrl write", {16'h0, host_ctrl}, 32'h0086);

    chk("R5 all expected writes seen", exp_q.size(), 32'h0);
    chk("R5 write count", n_mem, 32'd26);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule